// File: doc/BRIEF.md
# RAM-Fed Multi-Channel LED Dimmer

This block produces a bank of pulse-width-modulated outputs for LED brightness control. All channels share one free-running period counter, and each output stays high while that counter is below the channel's duty value. A period therefore lasts 2^DUTY_W clocks. With 16-bit duty values and a 65.536 MHz clock the refresh period is 1 ms. The default bank has 63 channels, which is enough for 21 red/green/blue LED groups.

The block keeps no per-channel registers that software can reach. Duty values live in a dual-port block RAM outside the block. The dimmer uses one port of that RAM, for reads only. The other port belongs to whatever host front end writes the intensities.

At the start of each period the block walks the RAM addresses once, one channel per clock, and fills a set of staging registers. At the counter wrap, every staging value moves into the active compare registers in the same clock. A host write can therefore never change a period that is already running, and every channel switches to its new duty on the same edge.

Top module: `pwm_ram_bank`

## Requirements
- R1: The period counter starts at 0 after reset and advances by one each clock. It wraps from 2^DUTY_W-1 to 0, so every period is exactly 2^DUTY_W clocks long.
- R2: Channel n drives `pwm_out[n]` high in exactly those cycles of a period whose counter value is strictly below its active duty. A duty of 0 keeps the output low for the whole period. A duty of 2^DUTY_W-1 keeps it high for every cycle except the last one.
- R3: In the cycle where the counter equals n, for n below CHANNELS, `ram_addr` equals n. In every other cycle `ram_addr` is 0. Channel n's duty value is stored at RAM address n.
- R4: The RAM returns its data on `ram_data` one clock after the address is presented. Each staging register takes the word read for its own address.
- R5: The active duty values change only on the clock edge where the counter wraps to 0, and they all change on that same edge. The value fetched during period k governs the whole of period k+1.
- R6: A host write to address n has no effect on the period in which it is made. If the write reaches the RAM before channel n's read in that period, it takes effect in the next period. Otherwise it takes effect in the period after the next.
- R7: While reset is asserted, `ram_addr` is 0 and all outputs are low. The active duties come out of reset at 0, so every output stays low for the whole first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_addr | output | ADDR_W = max(1, clog2(CHANNELS)) | Read address driven to the duty RAM |
| ram_data | input | DUTY_W | Read data from the duty RAM, one clock after the address |
| pwm_out | output | CHANNELS | One PWM output per channel |

## Verification
The assertions assume the RAM behaves as described in R4: it has exactly one clock of read latency, and when a read and a write hit the same address on the same edge it returns the old word. They also assume the parameters keep the fetch window shorter than a period. The bench RAM model registers its output once and applies host writes on the same edge. The bench also uses a small configuration, 6-bit duty values and 5 channels, so that a full period and every duty value can be swept. Host writes are timed on both sides of each channel's read cycle, and those timings are the cases that R6 separates.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   // Width of an index over n items, never less than one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] LAST = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

   // High during the final cycle; the following edge starts a new period.
   assign wrap_o = (cnt_o == LAST);

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/pwm_duty_fetch.sv
module pwm_duty_fetch #(
   parameter int unsigned CH = 63,
   parameter int unsigned W  = 16,
   parameter int unsigned AW = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         cnt_i,
   output logic [AW-1:0]        ram_addr_o,
   input  logic [W-1:0]         ram_data_i,
   output logic [CH-1:0][W-1:0] stage_o
);
   localparam logic [W-1:0] CH_W = W'(CH);

   logic          in_window;
   logic          pend_vld;
   logic [AW-1:0] pend_idx;

   assign in_window  = (cnt_i < CH_W);
   assign ram_addr_o = in_window ? cnt_i[AW-1:0] : '0;

   // The address goes out this cycle; its word arrives next cycle and is
   // written to the staging slot remembered in pend_idx.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_idx <= '0;
      end else begin
         pend_vld <= in_window;
         pend_idx <= ram_addr_o;
      end
   end

   for (genvar g = 0; g < CH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_o[g] <= '0;
         else if (pend_vld && (pend_idx == AW'(g)))
            stage_o[g] <= ram_data_i;
      end
   end

   assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_addr_o < AW'(CH));
   assert_fetch_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld |-> (cnt_i >= W'(1)) && (cnt_i <= CH_W));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_i,
   input  logic         load_i,
   input  logic [W-1:0] duty_i,
   output logic         pwm_o
);
   localparam logic [W-1:0] LAST = {W{1'b1}};

   logic [W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= '0;
      else if (load_i) act_q <= duty_i;
   end

   assign pwm_o = (cnt_i < act_q);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i != LAST) |=> $stable(act_q));
   assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> (cnt_i == '0));
   assert_last_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i == LAST) |-> !pwm_o);
endmodule

// File: rtl/pwm_ram_bank.sv
module pwm_ram_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned CHANNELS = 63,
   parameter int unsigned DUTY_W   = 16,
   localparam int unsigned ADDR_W  = idx_bits(CHANNELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [ADDR_W-1:0]   ram_addr,
   input  logic [DUTY_W-1:0]   ram_data,
   output logic [CHANNELS-1:0] pwm_out
);
   localparam longint unsigned PERIOD = 64'd1 << DUTY_W;

   initial begin
      assert (CHANNELS >= 1)
         else $error("pwm_ram_bank: CHANNELS must be at least 1");
      assert (DUTY_W >= 2 && DUTY_W <= 32)
         else $error("pwm_ram_bank: DUTY_W out of range");
      assert (longint'(CHANNELS) + 1 < PERIOD)
         else $error("pwm_ram_bank: fetch window must fit inside a period");
   end

   logic [DUTY_W-1:0]               cnt;
   logic                            wrap;
   logic [CHANNELS-1:0][DUTY_W-1:0] stage;

   pwm_period_ctr #(.W(DUTY_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   pwm_duty_fetch #(.CH(CHANNELS), .W(DUTY_W), .AW(ADDR_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt),
      .ram_addr_o (ram_addr),
      .ram_data_i (ram_data),
      .stage_o    (stage)
   );

   for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
      pwm_lane #(.W(DUTY_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .cnt_i  (cnt),
         .load_i (wrap),
         .duty_i (stage[g]),
         .pwm_o  (pwm_out[g])
      );
   end

   assert_reset_low_R7: assert property (@(posedge clk)
      !rst_n |-> (pwm_out == '0) && (ram_addr == '0));
endmodule

// File: tb/pwm_ram_bank_test.sv
module pwm_ram_bank_test;
   localparam int N   = 5;
   localparam int W   = 6;
   localparam int AW  = 3;
   localparam int PER = 1 << W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ram_addr;
   logic [W-1:0]  ram_data;
   logic [N-1:0]  pwm_out;

   // Host side of the RAM model.
   logic          we = 1'b0;
   logic [AW-1:0] wa = '0;
   logic [W-1:0]  wd = '0;
   logic [W-1:0]  mem [N];

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int mem_m [N];
   int exp_cur [N];

   always #2 clk = ~clk;

   // One-cycle read latency; a same-edge write returns the old word.
   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      ram_data <= (int'(ram_addr) < N) ? mem[ram_addr] : '0;
   end

   pwm_ram_bank #(.CHANNELS(N), .DUTY_W(W)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ram_addr (ram_addr),
      .ram_data (ram_data),
      .pwm_out  (pwm_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Run one full period and compare every output in every cycle.
   // wc < 0 means no host write; otherwise write wd_i to wa_i in cycle wc.
   task automatic run_period(input int wa_i, input int wd_i, input int wc);
      int nxt [N];
      for (int c = 0; c < PER; c++) begin
         #1;
         for (int ch = 0; ch < N; ch++) begin
            // R1 R2 R5: level follows the duty fetched in the previous period
            check(pwm_out[ch] == (c < exp_cur[ch]), "R2/R5 level",
                  int'(pwm_out[ch]), int'(c < exp_cur[ch]));
         end
         // R3: address sequence
         check(int'(ram_addr) == ((c < N) ? c : 0), "R3 ram_addr",
               int'(ram_addr), (c < N) ? c : 0);
         if (c == wc) begin
            we = 1'b1; wa = AW'(wa_i); wd = W'(wd_i);
         end
         @(negedge clk);
         we = 1'b0;
      end
      // R4 R6: channel ch is read in cycle ch; a write in an earlier cycle is seen.
      for (int ch = 0; ch < N; ch++)
         nxt[ch] = (wc >= 0 && wa_i == ch && wc < ch) ? wd_i : mem_m[ch];
      if (wc >= 0) mem_m[wa_i] = wd_i;
      for (int ch = 0; ch < N; ch++) exp_cur[ch] = nxt[ch];
   endtask

   initial begin
      int init_v [N] = '{10, 0, 63, 1, 33};
      for (int ch = 0; ch < N; ch++) begin
         exp_cur[ch] = 0;
         mem_m[ch] = init_v[ch];
      end
      // Preload the RAM through the host port while reset is held.
      for (int ch = 0; ch < N; ch++) begin
         @(negedge clk);
         we = 1'b1; wa = AW'(ch); wd = W'(init_v[ch]);
      end
      @(negedge clk);
      we = 1'b0;
      // R7: reset state
      check(pwm_out == '0, "R7 outputs in reset", int'(pwm_out), 0);
      check(ram_addr == '0, "R7 ram_addr in reset", int'(ram_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;

      run_period(0, 20, 30);  // R7: first period all low; R6: late write to ch0
      run_period(4, 5, 2);    // R6: early write to ch4
      run_period(2, 0, 60);   // R6: ch2 late write
      run_period(0, 0, -1);
      run_period(0, 0, -1);   // R2: duty 0 on ch2 takes effect
      // R2: sweep every duty on ch3 (late write) and ch1 (early write)
      for (int v = 0; v < PER; v++) run_period(3, v, 40);
      for (int v = PER - 1; v >= 0; v--) run_period(1, v, 0);
      run_period(0, 0, -1);
      run_period(0, 0, -1);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule